// File: doc/BRIEF.md
# Interrupt Logical Destination Matcher

This block sits in front of a local interrupt controller. It decides whether the unit takes an incoming interprocessor interrupt message. Software programs four settings through a narrow write port: a logical ID, a format selector (flat or cluster), a physical ID and a software-enable bit. Each message carries an 8-bit destination, a logical/physical mode bit, a 2-bit shorthand code, a 3-bit delivery mode and the sender's ID. The block compares these with its settings.

One cycle after a valid message, the block raises a registered accept flag when the message targets this unit. It raises a registered illegal flag when the message combines a cluster-mode broadcast with lowest-priority delivery. A sticky configuration-error bit records format writes that were out of order or used an unknown code.

Top module: `irq_dest_filter`

## Requirements
- R1: After reset, `accept`, `illegal` and `cfg_err` are 0, the format is flat, the logical ID and physical ID are 0, and software enable is clear.
- R2: A write with `cfg_we`=1 updates one setting, chosen by `cfg_sel`. Code 0 loads the logical ID from `cfg_wdata[31:24]`. Code 1 loads the format from `cfg_wdata[31:28]`. Code 2 loads the physical ID from `cfg_wdata[7:0]`. Code 3 loads software enable from `cfg_wdata[0]`.
- R3: Flat logical mode applies to shorthand 2'b00 with `msg_logical`=1 and the format set to flat. The unit accepts when enable is set and the bitwise AND of the destination and the logical ID is non-zero.
- R4: In cluster logical mode, the unit accepts when enable is set and all three of these hold: the destination's upper nibble equals the logical ID's upper nibble; that nibble is not 4'hF; and the lower nibbles share at least one set bit.
- R5: In either logical mode, with enable set, destination 8'hFF is accepted whatever the logical ID holds.
- R6: In cluster mode, a logical message with destination 8'hFF and delivery mode 3'b001 (lowest priority) sets `illegal` and is not accepted. This holds whether or not enable is set.
- R7: A physical message (`msg_logical`=0, shorthand 2'b00) is accepted when the destination equals the physical ID. Destination 8'hFF is also accepted while enable is set.
- R8: Shorthand 2'b01 (self) is always accepted. This holds regardless of enable, destination, mode bit, delivery mode and sender ID.
- R9: Shorthand 2'b10 (everyone) is accepted when enable is set. Shorthand 2'b11 (everyone else) is accepted when enable is set and the sender ID differs from the physical ID. Both ignore the destination and the mode bit.
- R10: Format value 4'hF selects flat mode and 4'h0 selects cluster mode. Any other value selects flat mode and sets `cfg_err`.
- R11: A format write while enable is set still takes effect, and it sets `cfg_err`. `cfg_err` stays set until reset.
- R12: `accept` and `illegal` reflect the message presented in the previous cycle. Both are 0 in the cycle after `msg_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select |
| cfg_wdata | input | 32 | Setting write data |
| msg_valid | input | 1 | Message present this cycle |
| msg_dest | input | 8 | Message destination |
| msg_logical | input | 1 | 1 = logical destination, 0 = physical |
| msg_short | input | 2 | Shorthand code |
| msg_dmode | input | 3 | Delivery mode |
| msg_src | input | 8 | Sender ID |
| accept | output | 1 | Message targets this unit (registered) |
| illegal | output | 1 | Forbidden broadcast/lowest-priority combination (registered) |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Every message is judged against the settings held before the current cycle's write. The assertions therefore assume that a setting write and a message never need to agree within one cycle. The stimulus always separates the two by at least one clock edge.

The assertions also assume that the shorthand and mode fields stay stable while `msg_valid` is high. The bench keeps each message for exactly one cycle and then drops `msg_valid`. Random destinations are steered toward the logical ID, the physical ID, 8'hFF and cluster nibble 4'hF, so that the narrow match cases occur often.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [1:0] {
    SH_NONE     = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL_INCL = 2'b10,
    SH_ALL_EXCL = 2'b11
  } shorthand_e;

  typedef enum logic [1:0] {
    SEL_LID = 2'd0,
    SEL_FMT = 2'd1,
    SEL_PID = 2'd2,
    SEL_EN  = 2'd3
  } cfg_sel_e;

  localparam logic [2:0] DM_LOWPRI = 3'b001;

endpackage

// File: rtl/dest_cfg_regs.sv
module dest_cfg_regs
  import irq_dest_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int FMT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ID_W-1:0]   lid,
  output logic [ID_W-1:0]   pid,
  output logic              sw_en,
  output logic              is_cluster,
  output logic              cfg_err,
  output logic              fmt_write_evt
);

  localparam logic [FMT_W-1:0] FMT_FLAT    = {FMT_W{1'b1}};
  localparam logic [FMT_W-1:0] FMT_CLUSTER = {FMT_W{1'b0}};

  // Decode a format code into {cluster, unknown}
  function automatic logic [1:0] fmt_decode(input logic [FMT_W-1:0] code);
    logic cl;
    logic bad;
    cl  = (code == FMT_CLUSTER);
    bad = (code != FMT_CLUSTER) && (code != FMT_FLAT);
    return {cl, bad};
  endfunction

  cfg_sel_e         sel;
  logic [FMT_W-1:0] fmt_code;
  logic [1:0]       fmt_info;
  logic             fmt_bad_evt;
  logic             fmt_late_evt;

  assign sel           = cfg_sel_e'(cfg_sel);
  assign fmt_code      = cfg_wdata[DATA_W-1 -: FMT_W];
  assign fmt_info      = fmt_decode(fmt_code);
  assign fmt_write_evt = cfg_we && (sel == SEL_FMT);
  assign fmt_bad_evt   = fmt_write_evt && fmt_info[0];
  assign fmt_late_evt  = fmt_write_evt && sw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lid        <= '0;
      pid        <= '0;
      sw_en      <= 1'b0;
      is_cluster <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        SEL_LID: lid        <= cfg_wdata[DATA_W-1 -: ID_W];
        SEL_FMT: is_cluster <= fmt_info[1];
        SEL_PID: pid        <= cfg_wdata[ID_W-1:0];
        SEL_EN:  sw_en      <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (fmt_bad_evt || fmt_late_evt) cfg_err <= 1'b1;
  end

endmodule

// File: rtl/dest_logical_match.sv
module dest_logical_match #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] dest,
  input  logic [ID_W-1:0] lid,
  input  logic            is_cluster,
  output logic            bcast,
  output logic            flat_hit,
  output logic            cluster_hit,
  output logic            logical_hit
);

  localparam int CL_W = ID_W / 2;

  logic [ID_W-1:0] overlap;

  genvar gi;
  generate
    for (gi = 0; gi < ID_W; gi++) begin : g_and
      assign overlap[gi] = dest[gi] & lid[gi];
    end
  endgenerate

  function automatic logic cluster_match(input logic [ID_W-1:0] d,
                                         input logic [ID_W-1:0] own,
                                         input logic [ID_W-1:0] ov);
    logic same_cl;
    logic valid_cl;
    same_cl  = (d[ID_W-1:CL_W] == own[ID_W-1:CL_W]);
    valid_cl = (d[ID_W-1:CL_W] != {(ID_W-CL_W){1'b1}});
    return same_cl && valid_cl && (|ov[CL_W-1:0]);
  endfunction

  assign bcast       = &dest;
  assign flat_hit    = |overlap;
  assign cluster_hit = cluster_match(dest, lid, overlap);
  assign logical_hit = bcast || (is_cluster ? cluster_hit : flat_hit);

endmodule

// File: rtl/dest_resolve.sv
module dest_resolve
  import irq_dest_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            msg_valid,
  input  logic [1:0]      msg_short,
  input  logic            msg_logical,
  input  logic [2:0]      msg_dmode,
  input  logic [ID_W-1:0] msg_dest,
  input  logic [ID_W-1:0] msg_src,
  input  logic [ID_W-1:0] pid,
  input  logic            sw_en,
  input  logic            is_cluster,
  input  logic            bcast,
  input  logic            logical_hit,
  output logic            accept_d,
  output logic            illegal_d
);

  shorthand_e sh;
  logic       phys_hit;
  logic       bad_combo;

  assign sh        = shorthand_e'(msg_short);
  assign phys_hit  = (msg_dest == pid) || (bcast && sw_en);
  assign bad_combo = msg_logical && is_cluster && bcast && (msg_dmode == DM_LOWPRI);

  always_comb begin
    accept_d  = 1'b0;
    illegal_d = 1'b0;
    if (msg_valid) begin
      case (sh)
        SH_SELF:     accept_d = 1'b1;
        SH_ALL_INCL: accept_d = sw_en;
        SH_ALL_EXCL: accept_d = sw_en && (msg_src != pid);
        default: begin
          if (msg_logical) begin
            illegal_d = bad_combo;
            accept_d  = sw_en && logical_hit && !bad_combo;
          end else begin
            accept_d  = phys_hit;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int FMT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              msg_valid,
  input  logic [ID_W-1:0]   msg_dest,
  input  logic              msg_logical,
  input  logic [1:0]        msg_short,
  input  logic [2:0]        msg_dmode,
  input  logic [ID_W-1:0]   msg_src,
  output logic              accept,
  output logic              illegal,
  output logic              cfg_err
);

  logic [ID_W-1:0] lid;
  logic [ID_W-1:0] pid;
  logic            sw_en;
  logic            is_cluster;
  logic            fmt_write_evt;
  logic            bcast;
  logic            flat_hit;
  logic            cluster_hit;
  logic            logical_hit;
  logic            accept_d;
  logic            illegal_d;

  dest_cfg_regs #(.DATA_W(DATA_W), .ID_W(ID_W), .FMT_W(FMT_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .lid           (lid),
    .pid           (pid),
    .sw_en         (sw_en),
    .is_cluster    (is_cluster),
    .cfg_err       (cfg_err),
    .fmt_write_evt (fmt_write_evt)
  );

  dest_logical_match #(.ID_W(ID_W)) u_lmatch (
    .dest        (msg_dest),
    .lid         (lid),
    .is_cluster  (is_cluster),
    .bcast       (bcast),
    .flat_hit    (flat_hit),
    .cluster_hit (cluster_hit),
    .logical_hit (logical_hit)
  );

  dest_resolve #(.ID_W(ID_W)) u_resolve (
    .msg_valid   (msg_valid),
    .msg_short   (msg_short),
    .msg_logical (msg_logical),
    .msg_dmode   (msg_dmode),
    .msg_dest    (msg_dest),
    .msg_src     (msg_src),
    .pid         (pid),
    .sw_en       (sw_en),
    .is_cluster  (is_cluster),
    .bcast       (bcast),
    .logical_hit (logical_hit),
    .accept_d    (accept_d),
    .illegal_d   (illegal_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      accept  <= accept_d;
      illegal <= illegal_d;
    end
  end

endmodule

// File: rtl/irq_dest_filter_chk.sv
module irq_dest_filter_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              msg_valid,
  input logic [1:0]        msg_short,
  input logic              msg_logical,
  input logic [ID_W-1:0]   msg_src,
  input logic              accept,
  input logic              illegal,
  input logic              cfg_err,
  input logic              sw_en,
  input logic [ID_W-1:0]   pid,
  input logic              fmt_write_evt
);

  // R8
  self_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_short == 2'b01) |=> accept);

  // R6
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !accept);

  // R3
  disabled_logical_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_short == 2'b00) && msg_logical && !sw_en |=> !accept);

  // R9
  excl_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_short == 2'b11) && (msg_src == pid) |=> !accept);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R11
  late_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_write_evt && sw_en |=> cfg_err);

  // R10
  bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_write_evt && (cfg_wdata[DATA_W-1 -: 4] != 4'hF) && (cfg_wdata[DATA_W-1 -: 4] != 4'h0)
    |=> cfg_err);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !accept && !illegal);

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_sel == 2'd3) |=> sw_en == $past(cfg_wdata[0]));

endmodule

bind irq_dest_filter irq_dest_filter_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/irq_dest_filter_test.sv
module irq_dest_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_dest = '0;
  logic        msg_logical = 1'b0;
  logic [1:0]  msg_short = 2'b00;
  logic [2:0]  msg_dmode = 3'b000;
  logic [7:0]  msg_src = '0;
  logic        accept;
  logic        illegal;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench-side copy of the settings, built from the requirements
  logic [7:0] m_lid = '0;
  logic [7:0] m_pid = '0;
  bit         m_en = 0;
  bit         m_cl = 0;
  bit         m_err = 0;

  always #10 clk = ~clk;

  irq_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_dest(msg_dest),
    .msg_logical(msg_logical), .msg_short(msg_short), .msg_dmode(msg_dmode),
    .msg_src(msg_src), .accept(accept), .illegal(illegal), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic bit ref_illegal(input logic [7:0] d, input bit lg,
                                     input logic [1:0] sh, input logic [2:0] dm);
    return (sh == 2'b00) && lg && m_cl && (d == 8'hFF) && (dm == 3'b001);
  endfunction

  function automatic bit ref_accept(input logic [7:0] d, input bit lg,
                                    input logic [1:0] sh, input logic [2:0] dm,
                                    input logic [7:0] s);
    bit hit;
    if (sh == 2'b01) return 1;
    if (sh == 2'b10) return m_en;
    if (sh == 2'b11) return m_en && (s != m_pid);
    if (!lg) return (d == m_pid) || (m_en && d == 8'hFF);
    if (ref_illegal(d, lg, sh, dm) || !m_en) return 0;
    if (d == 8'hFF) return 1;
    if (m_cl) begin
      hit = 0;
      for (int b = 0; b < 4; b++) if (d[b] && m_lid[b]) hit = 1;
      return (d[7:4] == m_lid[7:4]) && (d[7:4] != 4'hF) && hit;
    end
    hit = 0;
    for (int b = 0; b < 8; b++) if (d[b] && m_lid[b]) hit = 1;
    return hit;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_lid = data[31:24];
      2'd1: begin
        if (m_en || (data[31:28] != 4'hF && data[31:28] != 4'h0)) m_err = 1;
        m_cl = (data[31:28] == 4'h0);
      end
      2'd2: m_pid = data[7:0];
      default: m_en = data[0];
    endcase
  endtask

  task automatic send(input string req, input logic [7:0] d, input bit lg,
                      input logic [1:0] sh, input logic [2:0] dm, input logic [7:0] s);
    @(negedge clk);
    msg_valid = 1'b1; msg_dest = d; msg_logical = lg;
    msg_short = sh; msg_dmode = dm; msg_src = s;
    @(negedge clk);
    msg_valid = 1'b0;
    check({req, " accept"}, accept, ref_accept(d, lg, sh, dm, s));
    check({req, " illegal"}, illegal, ref_illegal(d, lg, sh, dm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 accept", accept, 1'b0);
    check("R1 illegal", illegal, 1'b0);
    check("R1 cfg_err", cfg_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: disabled, flat, lid 0 -> logical broadcast rejected; physical 0 hits pid 0
    send("R1 disabled bcast", 8'hFF, 1, 2'b00, 3'b000, 8'h00);
    send("R7 pid0 match", 8'h00, 0, 2'b00, 3'b000, 8'h00);
    // R8 self while disabled, sender equals own ID
    send("R8 self disabled", 8'h5A, 1, 2'b01, 3'b001, 8'h00);
    // R9 shorthands while disabled
    send("R9 incl disabled", 8'h00, 0, 2'b10, 3'b000, 8'h33);
    // R2 program settings
    cfg_write(2'd0, 32'h2400_0000);
    cfg_write(2'd2, 32'h0000_0017);
    cfg_write(2'd3, 32'h0000_0001);
    check("R11 no err yet", cfg_err, 1'b0);
    // R3 flat
    send("R3 flat hit", 8'h04, 1, 2'b00, 3'b000, 8'h01);
    send("R3 flat miss", 8'h42, 1, 2'b00, 3'b000, 8'h01);
    // R5 flat broadcast
    send("R5 flat bcast", 8'hFF, 1, 2'b00, 3'b001, 8'h01);
    // R7 physical
    send("R7 phys hit", 8'h17, 0, 2'b00, 3'b000, 8'h01);
    send("R7 phys miss", 8'h24, 0, 2'b00, 3'b000, 8'h01);
    send("R7 phys bcast", 8'hFF, 0, 2'b00, 3'b000, 8'h01);
    // R9 exclude-self with sender equal to own ID, and different
    send("R9 excl self", 8'h17, 0, 2'b11, 3'b000, 8'h17);
    send("R9 excl other", 8'h00, 1, 2'b11, 3'b000, 8'h16);
    // R10 R11 go to cluster: disable, write format, enable
    cfg_write(2'd3, 32'h0);
    cfg_write(2'd1, 32'h0FFF_FFFF);
    check("R10 cluster no err", cfg_err, 1'b0);
    cfg_write(2'd3, 32'h1);
    // R4 cluster 2, members bit2
    send("R4 cluster hit", 8'h2C, 1, 2'b00, 3'b000, 8'h01);
    send("R4 wrong cluster", 8'h34, 1, 2'b00, 3'b000, 8'h01);
    send("R4 member miss", 8'h23, 1, 2'b00, 3'b000, 8'h01);
    // R5 R6 cluster broadcast, fixed and lowest priority
    send("R5 cluster bcast", 8'hFF, 1, 2'b00, 3'b000, 8'h01);
    send("R6 bcast lowpri", 8'hFF, 1, 2'b00, 3'b001, 8'h01);
    // R4 cluster nibble F never matches unless broadcast
    cfg_write(2'd3, 32'h0);
    cfg_write(2'd0, 32'hF500_0000);
    send("R6 lowpri disabled", 8'hFF, 1, 2'b00, 3'b001, 8'h01);
    cfg_write(2'd3, 32'h1);
    send("R4 cluster F", 8'hF4, 1, 2'b00, 3'b000, 8'h01);
    // R11 format write while enabled
    cfg_write(2'd1, 32'hF000_0000);
    check("R11 late fmt err", cfg_err, 1'b1);
    send("R11 flat took effect", 8'h04, 1, 2'b00, 3'b000, 8'h01);
    // R12 idle cycle
    @(negedge clk);
    check("R12 idle accept", accept, 1'b0);
    check("R12 idle illegal", illegal, 1'b0);
    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      logic [1:0] sh;
      int pick;
      if ($urandom_range(0, 15) == 0) begin
        pick = $urandom_range(0, 4);
        case (pick)
          0: cfg_write(2'd0, {8'($urandom()), 24'h0});
          1: cfg_write(2'd1, {($urandom_range(0, 3) == 0) ? 4'($urandom()) :
                              ($urandom_range(0, 1) ? 4'hF : 4'h0), 28'h0});
          2: cfg_write(2'd2, 32'($urandom_range(0, 255)));
          default: cfg_write(2'd3, 32'($urandom_range(0, 1)));
        endcase
        // R10 R11 error flag follows the bench model
        check("R11 err model", cfg_err, m_err);
      end
      pick = $urandom_range(0, 5);
      case (pick)
        0: d = 8'hFF;
        1: d = m_pid;
        2: d = {m_lid[7:4], 4'($urandom())};
        3: d = {4'hF, 4'($urandom())};
        default: d = 8'($urandom());
      endcase
      sh = ($urandom_range(0, 3) == 0) ? 2'($urandom()) : 2'b00;
      send("R3 R4 R7 random", d, 1'($urandom()), sh, 3'($urandom()),
           ($urandom_range(0, 3) == 0) ? m_pid : 8'($urandom()));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule